// File: doc/BRIEF.md
# Serial Peripheral Slave Shift Engine with Select Synchronization

This block is the receive/transmit core of a serial peripheral slave. An external master drives the serial clock. The block moves one 8-bit word per transfer, most-significant bit first, in both directions at the same time. All serial pins are brought into the system clock domain through synchronizer flops, and the serial clock edges are detected from those synchronized samples. The serial clock must stay high and low for at least 4 system clocks in each phase.

The system side loads the next outgoing word with a single-cycle write strobe. It collects the incoming word from a receive buffer and acknowledges it with a read strobe. A completion flag is set after each word and is cleared by a write-one pulse. Two sticky error flags report a write that arrived mid-word and a word that arrived before the previous one was read. With select control on, a high level on the active-low select input aborts the word in progress. The data output enable also drops at once on a high select, even partway through a word.

Top module: `spis_slave`

## Requirements
- R1: A transfer is 8 bits, shifted most-significant bit first on both `sdo` and `sdi`. On the 8th sample edge the received word appears on `rx_data` and `irq` is set.
- R2: `ckp` gives the idle level of `sck` (0 = idle low, 1 = idle high). Both edge roles invert with it, so transfers work the same at either polarity.
- R3: With `cke`=1, the first bit appears on `sdo` when `ss_n` falls. `sdi` is sampled on each idle-to-active edge, and `sdo` moves to the next bit on each active-to-idle edge.
- R4: With `cke`=0, `sdo` changes on each idle-to-active edge and `sdi` is sampled on each active-to-idle edge. When `sel_ctrl`=0, transfers run on `sck` alone and `sdo_oe` stays high while `en`=1.
- R5: `sdo_oe` is 1 exactly when `en`=1 and either `sel_ctrl`=0 or `ss_n` is low. It falls in the same cycle that `ss_n` rises, with no clock edge needed.
- R6: With `sel_ctrl`=1, a high `ss_n` forces the bit count to zero. A partly shifted word never raises `irq`, and the next full word is received and sent correctly.
- R7: `en`=0 forces the bit count to zero and drops `sdo_oe`. After `en` returns, a full word transfers correctly.
- R8: A `tx_wr` that arrives after at least one bit of the current word has been sampled is ignored: the outgoing word continues unchanged. It also sets `wcol`, which stays set until an `err_clr` pulse.
- R9: If a word completes while the previous received word is still unread (no `rx_rd` since it completed), `ovf` is set and stays set until `err_clr`. `rx_data` then holds the newer word.
- R10: `irq` stays set until an `irq_clr` pulse. Time without a clear, and further edges, leave it set.
- R11: `cke`=1 is only legal while `sel_ctrl`=1 and `en`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable; low holds the bit count at zero |
| ckp | input | 1 | Serial clock idle level |
| cke | input | 1 | Edge role select (1: sample on idle-to-active) |
| sel_ctrl | input | 1 | Select pin control enable |
| sck_i | input | 1 | External serial clock |
| ss_n_i | input | 1 | Active-low slave select |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data out pad |
| tx_wr | input | 1 | Load strobe for the outgoing word |
| tx_data | input | DATA_W | Outgoing word |
| rx_rd | input | 1 | Acknowledge that the received word was read |
| rx_data | output | DATA_W | Last received word |
| irq | output | 1 | Word-complete flag |
| irq_clr | input | 1 | Write-one clear of `irq` |
| err_clr | input | 1 | Clear of `wcol` and `ovf` |
| wcol | output | 1 | Sticky write-collision flag |
| ovf | output | 1 | Sticky receive overflow flag |

## Verification
Assertions check on every cycle that a held-off engine (select high or disable) sits at bit count zero, that word completion raises the flag, and that the flag holds until cleared. They also check that a busy write raises the collision flag, that an unread word followed by a completion raises overflow, and that the edge role option is never used without select control. Only the bench scenarios can show that bit order, edge roles and polarity line up with a real master across all four clock modes. They also show that an aborted or disabled partial word leaves the next word intact, and that the output enable drops immediately on select release.

// File: rtl/spis_pkg.sv
package spis_pkg;
   typedef struct packed {
      logic sck;
      logic ss_n;
      logic sdi;
   } spis_pins_t;

   typedef struct packed {
      logic lead;     // idle-to-active edge
      logic trail;    // active-to-idle edge
      logic ss_fall;  // select asserted
   } spis_edges_t;
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("spis_sync: STAGES must be at least 2");
      end
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
         end
         assign q[b] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/spis_edges.sv
module spis_edges
   import spis_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  spis_pins_t  pins_s,
   input  logic        ckp,
   output spis_edges_t edges
);
   logic lvl, lvl_q, ss_q;

   assign lvl = pins_s.sck ^ ckp;   // 1 while in the active phase

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
         ss_q  <= 1'b1;
      end else begin
         lvl_q <= lvl;
         ss_q  <= pins_s.ss_n;
      end
   end

   assign edges.lead    = lvl & ~lvl_q;
   assign edges.trail   = ~lvl & lvl_q;
   assign edges.ss_fall = ~pins_s.ss_n & ss_q;
endmodule

// File: rtl/spis_shift.sv
module spis_shift
   import spis_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cke,
   input  logic              sel_ctrl,
   input  spis_pins_t        pins_s,
   input  spis_edges_t       edges,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   input  logic              irq_clr,
   input  logic              err_clr,
   output logic              sdo_bit,
   output logic [DATA_W-1:0] rx_data,
   output logic              irq,
   output logic              wcol,
   output logic              ovf
);
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic              rx_full;
   logic              hold, samp, drive, busy, last, done, wr_ok, collide;

   assign hold    = ~en | (sel_ctrl & pins_s.ss_n);
   assign samp    = ~hold & (cke ? edges.lead  : edges.trail);
   assign drive   = ~hold & (cke ? edges.trail : edges.lead);
   assign busy    = (cnt != '0);
   assign last    = (cnt == CNT_W'(DATA_W - 1));
   assign done    = samp & last;
   assign wr_ok   = tx_wr & ~busy & ~samp;
   assign collide = tx_wr & ~wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         shreg   <= '0;
         sdo_bit <= 1'b0;
         rx_data <= '0;
         rx_full <= 1'b0;
         irq     <= 1'b0;
         wcol    <= 1'b0;
         ovf     <= 1'b0;
      end else begin
         if (hold)      cnt <= '0;
         else if (samp) cnt <= last ? '0 : cnt + CNT_W'(1);

         if (samp)       shreg <= {shreg[DATA_W-2:0], pins_s.sdi};
         else if (wr_ok) shreg <= tx_data;

         if (wr_ok)      sdo_bit <= tx_data[DATA_W-1];
         else if (drive) sdo_bit <= shreg[DATA_W-1];
         else if (cke && sel_ctrl && en && edges.ss_fall)
                         sdo_bit <= shreg[DATA_W-1];

         if (done) rx_data <= {shreg[DATA_W-2:0], pins_s.sdi};

         if (done)       rx_full <= 1'b1;
         else if (rx_rd) rx_full <= 1'b0;

         if (done)         irq <= 1'b1;
         else if (irq_clr) irq <= 1'b0;

         if (collide)      wcol <= 1'b1;
         else if (err_clr) wcol <= 1'b0;

         if (done && rx_full && !rx_rd) ovf <= 1'b1;
         else if (err_clr)              ovf <= 1'b0;
      end
   end

   assert_hold_clears_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt == '0));
   assert_done_sets_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> irq);
   assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);
   assert_busy_write_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && busy) |=> wcol);
   assert_unread_word_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_full && !rx_rd) |=> ovf);
endmodule

// File: rtl/spis_slave.sv
module spis_slave
   import spis_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              ckp,
   input  logic              cke,
   input  logic              sel_ctrl,
   input  logic              sck_i,
   input  logic              ss_n_i,
   input  logic              sdi_i,
   output logic              sdo_o,
   output logic              sdo_oe,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              rx_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              irq,
   input  logic              irq_clr,
   input  logic              err_clr,
   output logic              wcol,
   output logic              ovf
);
   localparam int PIN_W = $bits(spis_pins_t);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("spis_slave: DATA_W must be at least 2");
      end
   endgenerate

   spis_pins_t  pins_raw, pins_s;
   spis_edges_t edges;
   logic        sdo_bit;

   assign pins_raw = '{sck: sck_i, ss_n: ss_n_i, sdi: sdi_i};

   spis_sync #(
      .WIDTH  (PIN_W),
      .STAGES (SYNC_STAGES),
      .RST_VAL(PIN_W'(3'b010))
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pins_raw),
      .q    (pins_s)
   );

   spis_edges u_edges (
      .clk   (clk),
      .rst_n (rst_n),
      .pins_s(pins_s),
      .ckp   (ckp),
      .edges (edges)
   );

   spis_shift #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .cke     (cke),
      .sel_ctrl(sel_ctrl),
      .pins_s  (pins_s),
      .edges   (edges),
      .tx_wr   (tx_wr),
      .tx_data (tx_data),
      .rx_rd   (rx_rd),
      .irq_clr (irq_clr),
      .err_clr (err_clr),
      .sdo_bit (sdo_bit),
      .rx_data (rx_data),
      .irq     (irq),
      .wcol    (wcol),
      .ovf     (ovf)
   );

   // Output enable follows the raw select pin so release needs no clock edge.
   assign sdo_oe = en & (~sel_ctrl | ~ss_n_i);
   assign sdo_o  = sdo_bit;

   assert_cke_needs_select_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (en && cke) |-> sel_ctrl);
endmodule

// File: tb/spis_slave_tb.sv
module spis_slave_tb;
   localparam int H = 6;   // system clocks per serial half period

   logic clk = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic       rst_n = 1'b0, en = 1'b0, ckp = 1'b0, cke = 1'b0, sel_ctrl = 1'b1;
   logic       sck = 1'b0, ss_n = 1'b1, sdi = 1'b0;
   logic       sdo, sdo_oe, tx_wr = 1'b0, rx_rd = 1'b0, irq_clr = 1'b0, err_clr = 1'b0;
   logic [7:0] tx_data = '0, rx_data;
   logic       irq, wcol, ovf;

   spis_slave u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .ckp(ckp), .cke(cke), .sel_ctrl(sel_ctrl),
      .sck_i(sck), .ss_n_i(ss_n), .sdi_i(sdi), .sdo_o(sdo), .sdo_oe(sdo_oe),
      .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
      .irq(irq), .irq_clr(irq_clr), .err_clr(err_clr), .wcol(wcol), .ovf(ovf)
   );

   int         n_chk = 0, n_bad = 0;
   bit         finished = 1'b0;
   bit         auto_read = 1'b1;
   logic [7:0] exp_q[$];
   logic [7:0] sdo_acc;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic p, input logic e, input logic s);
      en = 1'b0; tick(1);
      ckp = p; cke = e; sel_ctrl = s; sck = p; ss_n = 1'b1;
      tick(6); en = 1'b1; tick(2);
   endtask

   task automatic wr(input logic [7:0] d);
      tx_data = d; tx_wr = 1'b1; tick(1); tx_wr = 1'b0; tick(1);
   endtask

   task automatic ss_low;
      ss_n = 1'b0; tick(2*H);
   endtask

   // Master side: drives bits hi..lo of m, collects sdo into sdo_acc.
   task automatic bits(input logic [7:0] m, input int hi, input int lo);
      for (int i = hi; i >= lo; i--) begin
         if (cke) begin
            sdi = m[i]; tick(H);
            sdo_acc = {sdo_acc[6:0], sdo};
            sck = ~ckp; tick(H); sck = ckp;
         end else begin
            sck = ~ckp; sdi = m[i]; tick(H);
            sdo_acc = {sdo_acc[6:0], sdo};
            sck = ckp; tick(H);
         end
      end
      tick(H);
   endtask

   task automatic xfer(input logic [7:0] m, input logic [7:0] exp_sdo, input string req);
      exp_q.push_back(m);
      sdo_acc = '0;
      bits(m, 7, 0);
      chk({req, " sdo word"}, sdo_acc, exp_sdo);
      tick(4);
      chk({req, " scoreboard drained"}, exp_q.size(), 0);
   endtask

   // Monitor: pops expected words as the design reports them.
   initial begin
      forever begin
         @(negedge clk);
         if (irq && auto_read) begin
            if (exp_q.size() == 0) chk("R1 unexpected word", 1, 0);
            else                   chk("R1 rx word", rx_data, exp_q.pop_front());
            rx_rd = 1'b1; irq_clr = 1'b1;
            @(negedge clk);
            rx_rd = 1'b0; irq_clr = 1'b0;
         end
      end
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      tick(4); rst_n = 1'b1; tick(2);
      // reset state
      chk("R7 reset oe", sdo_oe, 0);
      chk("R10 reset irq", irq, 0);
      chk("R8 reset wcol", wcol, 0);
      chk("R9 reset ovf", ovf, 0);
      chk("R1 reset rx", rx_data, 8'h00);

      // R3/R5: cke=1, idle low, select control on
      cfg(1'b0, 1'b1, 1'b1);
      wr(8'hA5);
      chk("R5 oe with select high", sdo_oe, 0);
      ss_low;
      chk("R5 oe with select low", sdo_oe, 1);
      xfer(8'h3C, 8'hA5, "R3 mode cke1 ckp0");
      ss_n = 1'b1; #1;
      chk("R5 oe release", sdo_oe, 0);
      tick(2);

      // R2: idle high, cke=1
      cfg(1'b1, 1'b1, 1'b1);
      wr(8'h5A); ss_low;
      xfer(8'hC3, 8'h5A, "R2 mode cke1 ckp1");
      ss_n = 1'b1; tick(2);

      // R4: cke=0, no select control, two back-to-back words
      cfg(1'b0, 1'b0, 1'b0);
      wr(8'h81);
      chk("R4 oe without select", sdo_oe, 1);
      xfer(8'h7E, 8'h81, "R4 mode cke0 ckp0");
      wr(8'hE7);
      xfer(8'h18, 8'hE7, "R4 second word");

      // R2/R4: cke=0 idle high with select
      cfg(1'b1, 1'b0, 1'b1);
      wr(8'h96); ss_low;
      xfer(8'h69, 8'h96, "R2 mode cke0 ckp1");
      ss_n = 1'b1; tick(2);

      // R6: abort mid-word
      cfg(1'b0, 1'b1, 1'b1);
      wr(8'hF0); ss_low;
      sdo_acc = '0;
      bits(8'h55, 7, 5);
      ss_n = 1'b1; #1;
      chk("R6 oe drops mid-word", sdo_oe, 0);
      tick(10);
      chk("R6 no irq after abort", irq, 0);
      wr(8'h2D); ss_low;
      xfer(8'hB4, 8'h2D, "R6 word after abort");
      ss_n = 1'b1; tick(2);

      // R8: write collision
      cfg(1'b0, 1'b1, 1'b1);
      wr(8'hC6); ss_low;
      exp_q.push_back(8'h3B);
      sdo_acc = '0;
      bits(8'h3B, 7, 5);
      wr(8'hFF);
      chk("R8 wcol set", wcol, 1);
      bits(8'h3B, 4, 0);
      chk("R8 sdo unchanged by ignored write", sdo_acc, 8'hC6);
      tick(4);
      chk("R8 scoreboard drained", exp_q.size(), 0);
      ss_n = 1'b1; tick(2);
      chk("R8 wcol sticky", wcol, 1);
      err_clr = 1'b1; tick(1); err_clr = 1'b0; tick(1);
      chk("R8 wcol cleared", wcol, 0);

      // R9/R10: overflow and sticky flag
      auto_read = 1'b0;
      cfg(1'b0, 1'b0, 1'b0);
      wr(8'h11);
      bits(8'hA1, 7, 0);
      tick(2);
      chk("R10 irq set", irq, 1);
      tick(20);
      chk("R10 irq sticky", irq, 1);
      chk("R9 no ovf yet", ovf, 0);
      wr(8'h22);
      bits(8'hB2, 7, 0);
      tick(2);
      chk("R9 ovf set", ovf, 1);
      chk("R9 newer word kept", rx_data, 8'hB2);
      irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
      chk("R10 irq cleared", irq, 0);
      rx_rd = 1'b1; err_clr = 1'b1; tick(1); rx_rd = 1'b0; err_clr = 1'b0; tick(1);
      chk("R9 ovf cleared", ovf, 0);
      auto_read = 1'b1;

      // R7: disable mid-word
      cfg(1'b0, 1'b1, 1'b1);
      wr(8'h99); ss_low;
      bits(8'h12, 7, 4);
      en = 1'b0; #1;
      chk("R7 oe off when disabled", sdo_oe, 0);
      tick(4); en = 1'b1; tick(2);
      wr(8'h4E);
      chk("R7 write accepted after disable", wcol, 0);
      xfer(8'hE4, 8'h4E, "R7 word after disable");
      ss_n = 1'b1; tick(4);

      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule